// File: doc/BRIEF.md
# HD Video Line Number and CRC Inserter

This block sits in the transmit path of a high-definition serial digital video link, just ahead of the scrambler. It carries two parallel 10-bit word streams, luma (Y) and chroma (C), and takes one word of each per clock. Each stream is watched on its own for the four-word timing reference that closes a line's active picture. After that reference, the four words that follow are overwritten. The first two carry the current line number. The last two carry an 18-bit CRC of that stream's line.

The line number is an 11-bit value supplied by the upstream video source. It is captured in the cycle in which the closing reference word arrives. Each stream keeps its own CRC. The CRC restarts on the first active word after the timing reference that opens the line, and it accumulates up to and including the second line-number word. Every word outside the four inserted slots leaves the block unchanged, one clock after it entered. The latency is the same for Y and for C.

Top module: `hd_ln_crc_inserter`

## Requirements
- R1: A word that is not in an insertion slot appears unchanged on the matching output exactly one clock after it is presented. Y and C have the same latency.
- R2: A timing reference is the words 0x3FF, 0x000, 0x000 followed by a status word. The closing reference, which starts insertion, has bit 6 of the status word at 1. With bit 6 at 0 the reference is an opening reference and starts no insertion. Any break in the 0x3FF, 0x000, 0x000 prefix means no reference is recognised.
- R3: The two words after a closing status word carry the line number. In the first, bits 8:2 = line[6:0]. In the second, bits 5:2 = line[10:7] and bits 8:6 = 0. In both, bits 1:0 = 0 and bit 9 = NOT bit 8.
- R4: The line number inserted is the value on `line_num` in the cycle the closing status word is presented. Later changes do not affect the two words already scheduled.
- R5: The CRC of each stream has 18 bits and uses the generator x^18+x^5+x^4+1. It is computed LSB first with a right-shifting register: the feedback is crc[0] XOR the data bit, and a feedback of 1 XORs the mask 0x23000 into the shifted value. It starts from zero on the first word after an opening status word. It then takes in every output word through the second line-number word.
- R6: The third slot after the closing status word carries crc[8:0] in bits 8:0. The fourth slot carries crc[17:9] in bits 8:0. In both, bit 9 = NOT bit 8.
- R7: Y and C find their references and compute their CRCs independently. A reference on one stream leaves the other stream untouched.
- R8: While `rst` is high at a clock edge, both outputs become 0. The reset clears the slot sequence and the CRC state, so an insertion under way is abandoned, and the words after reset pass through unchanged.
- R9: While the four slots are running, a closing reference whose status word lands in a slot is ignored. The word after the fourth slot passes through unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Word clock |
| rst | input | 1 | Synchronous reset, active high |
| y_in | input | 10 | Luma word in |
| c_in | input | 10 | Chroma word in |
| line_num | input | 11 | Current line number from the video source |
| y_out | output | 10 | Luma word out with inserted words |
| c_out | output | 10 | Chroma word out with inserted words |

## Verification
The assertions assume that `y_in`, `c_in` and `line_num` are known, non-X values in every clock after reset is released. They also assume that the source may place timing references anywhere, including inside slots, so detection relies only on the last three raw words. The stimulus drives a defined word on every cycle. It builds whole lines from opening reference, active words, closing reference, slot placeholders and blanking. It then adds deliberate near-miss prefixes, references landing inside slots, and a reset in the middle of a slot sequence, all of which stay inside those assumptions.

// File: rtl/ln_crc_pkg.sv
`timescale 1ns/1ps
package ln_crc_pkg;

    localparam int WORD_W     = 10;
    localparam int LINE_W     = 11;
    localparam int CRC_W      = 18;
    localparam int PREFIX_LEN = 3;
    localparam int H_BIT      = 6;
    localparam int NUM_LANES  = 2;

    localparam logic [CRC_W-1:0]  CRC_MASK  = 18'h23000;
    localparam logic [WORD_W-1:0] WORD_ONES = {WORD_W{1'b1}};
    localparam logic [WORD_W-1:0] WORD_ZERO = '0;

    typedef enum logic [2:0] {
        SLOT_IDLE = 3'd0,
        SLOT_LN0  = 3'd1,
        SLOT_LN1  = 3'd2,
        SLOT_CRC0 = 3'd3,
        SLOT_CRC1 = 3'd4
    } slot_e;

    function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] seed,
                                                   input logic [WORD_W-1:0] data);
        logic [CRC_W-1:0] acc;
        logic             fb;
        acc = seed;
        for (int b = 0; b < WORD_W; b++) begin
            fb  = acc[0] ^ data[b];
            acc = acc >> 1;
            if (fb) acc = acc ^ CRC_MASK;
        end
        return acc;
    endfunction

endpackage

// File: rtl/ln_crc_trs_detect.sv
`timescale 1ns/1ps
module ln_crc_trs_detect
    import ln_crc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              scan_en,
    input  logic [WORD_W-1:0] word_in,
    output logic              eav_hit,
    output logic              sav_hit
);

    typedef struct packed {
        logic [PREFIX_LEN-1:0][WORD_W-1:0] hist;
    } det_state_t;

    det_state_t state_d, state_q;
    logic [PREFIX_LEN-1:0] pos_ok;
    logic                  prefix_ok;

    // hist[0] is the newest raw word, hist[PREFIX_LEN-1] the oldest
    always_comb begin
        state_d = state_q;
        state_d.hist[0] = word_in;
        for (int i = 1; i < PREFIX_LEN; i++) begin
            state_d.hist[i] = state_q.hist[i-1];
        end
    end

    generate
        for (genvar g = 0; g < PREFIX_LEN; g++) begin : g_prefix
            if (g == PREFIX_LEN - 1) begin : g_lead
                assign pos_ok[g] = (state_q.hist[g] == WORD_ONES);
            end else begin : g_zero
                assign pos_ok[g] = (state_q.hist[g] == WORD_ZERO);
            end
        end
    endgenerate

    assign prefix_ok = &pos_ok;
    assign eav_hit   = scan_en &&  prefix_ok &&  word_in[H_BIT];
    assign sav_hit   =             prefix_ok && !word_in[H_BIT];

    always_ff @(posedge clk) begin
        if (rst) state_q <= '0;
        else     state_q <= state_d;
    end

    // R2: a closing reference is only reported after the full three-word prefix
    assert_eav_prefix_R2: assert property (@(posedge clk) disable iff (rst)
        eav_hit |-> ($past(word_in, 1) == WORD_ZERO &&
                     $past(word_in, 2) == WORD_ZERO &&
                     $past(word_in, 3) == WORD_ONES));

endmodule

// File: rtl/ln_crc_crc18.sv
`timescale 1ns/1ps
module ln_crc_crc18
    import ln_crc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              seed_zero,
    input  logic              accum,
    input  logic [WORD_W-1:0] word_in,
    output logic [CRC_W-1:0]  crc_out
);

    typedef struct packed {
        logic [CRC_W-1:0] crc;
    } crc_state_t;

    crc_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (accum) begin
            state_d.crc = crc_step(seed_zero ? '0 : state_q.crc, word_in);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= '0;
        else     state_q <= state_d;
    end

    assign crc_out = state_q.crc;

endmodule

// File: rtl/ln_crc_lane.sv
`timescale 1ns/1ps
module ln_crc_lane
    import ln_crc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] word_in,
    input  logic [LINE_W-1:0] line_num,
    output logic [WORD_W-1:0] word_out
);

    typedef struct packed {
        slot_e              slot;
        logic [LINE_W-1:0]  ln;
        logic               crc_start;
        logic               crc_en;
        logic [WORD_W-1:0]  out;
    } lane_state_t;

    lane_state_t       state_d, state_q;
    logic              eav_hit, sav_hit;
    logic [CRC_W-1:0]  crc_val;
    logic [WORD_W-1:0] mux_word;

    ln_crc_trs_detect i_detect (
        .clk     (clk),
        .rst     (rst),
        .scan_en (state_q.slot == SLOT_IDLE),
        .word_in (word_in),
        .eav_hit (eav_hit),
        .sav_hit (sav_hit)
    );

    ln_crc_crc18 i_crc (
        .clk       (clk),
        .rst       (rst),
        .seed_zero (state_q.crc_start),
        .accum     (state_q.crc_start || state_q.crc_en),
        .word_in   (mux_word),
        .crc_out   (crc_val)
    );

    always_comb begin
        case (state_q.slot)
            SLOT_LN0:  mux_word = {~state_q.ln[6], state_q.ln[6:0], 2'b00};
            SLOT_LN1:  mux_word = {1'b1, 3'b000, state_q.ln[10:7], 2'b00};
            SLOT_CRC0: mux_word = {~crc_val[8], crc_val[8:0]};
            SLOT_CRC1: mux_word = {~crc_val[17], crc_val[17:9]};
            default:   mux_word = word_in;
        endcase
    end

    always_comb begin
        state_d = state_q;
        state_d.out       = mux_word;
        state_d.crc_start = sav_hit;

        if (state_q.slot == SLOT_LN1)  state_d.crc_en = 1'b0;
        else if (state_q.crc_start)    state_d.crc_en = 1'b1;

        if (eav_hit) state_d.ln = line_num;

        case (state_q.slot)
            SLOT_IDLE: state_d.slot = eav_hit ? SLOT_LN0 : SLOT_IDLE;
            SLOT_LN0:  state_d.slot = SLOT_LN1;
            SLOT_LN1:  state_d.slot = SLOT_CRC0;
            SLOT_CRC0: state_d.slot = SLOT_CRC1;
            default:   state_d.slot = SLOT_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= '0;
        else     state_q <= state_d;
    end

    assign word_out = state_q.out;

    // R1: outside the slots a word leaves one clock later unchanged
    assert_pass_through_R1: assert property (@(posedge clk) disable iff (rst)
        (state_q.slot == SLOT_IDLE) |=> (word_out == $past(word_in)));

    // R9: a detected closing reference always opens the slot sequence at LN0
    assert_slot_start_R9: assert property (@(posedge clk) disable iff (rst)
        eav_hit |=> (state_q.slot == SLOT_LN0));

    // R3: line-number words have zero low bits and an inverted top bit
    assert_ln_format_R3: assert property (@(posedge clk) disable iff (rst)
        (state_q.slot == SLOT_LN0 || state_q.slot == SLOT_LN1) |=>
        (word_out[1:0] == 2'b00 && word_out[9] == ~word_out[8]));

    // R3: upper line-number word has bits 8:6 cleared
    assert_ln_high_R3: assert property (@(posedge clk) disable iff (rst)
        (state_q.slot == SLOT_LN1) |=> (word_out[8:6] == 3'b000));

    // R6: CRC words carry an inverted bit 9
    assert_crc_format_R6: assert property (@(posedge clk) disable iff (rst)
        (state_q.slot == SLOT_CRC0 || state_q.slot == SLOT_CRC1) |=>
        (word_out[9] == ~word_out[8]));

endmodule

// File: rtl/hd_ln_crc_inserter.sv
`timescale 1ns/1ps
module hd_ln_crc_inserter
    import ln_crc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] y_in,
    input  logic [WORD_W-1:0] c_in,
    input  logic [LINE_W-1:0] line_num,
    output logic [WORD_W-1:0] y_out,
    output logic [WORD_W-1:0] c_out
);

    logic [NUM_LANES-1:0][WORD_W-1:0] lane_in;
    logic [NUM_LANES-1:0][WORD_W-1:0] lane_out;

    assign lane_in[0] = y_in;
    assign lane_in[1] = c_in;

    // R7: each stream owns its detector, slot sequence and CRC
    generate
        for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
            ln_crc_lane i_lane (
                .clk      (clk),
                .rst      (rst),
                .word_in  (lane_in[g]),
                .line_num (line_num),
                .word_out (lane_out[g])
            );
        end
    endgenerate

    assign y_out = lane_out[0];
    assign c_out = lane_out[1];

    // R8: a reset edge leaves both outputs at zero
    assert_reset_clear_R8: assert property (@(posedge clk)
        rst |=> (y_out == WORD_ZERO && c_out == WORD_ZERO));

endmodule

// File: tb/test_hd_ln_crc_inserter.sv
`timescale 1ns/1ps
module test_hd_ln_crc_inserter;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [9:0]  y_in = '0;
    logic [9:0]  c_in = '0;
    logic [10:0] line_num = '0;
    logic [9:0]  y_out, c_out;

    int n_tests = 0;
    int n_fail  = 0;

    always #4 clk = ~clk;

    hd_ln_crc_inserter i_hd_ln_crc_inserter (
        .clk(clk), .rst(rst), .y_in(y_in), .c_in(c_in),
        .line_num(line_num), .y_out(y_out), .c_out(c_out)
    );

    // one video line: {y, c}
    localparam int NVEC = 24;
    localparam logic [19:0] VEC [NVEC] = '{
        {10'h3FF, 10'h3FF}, {10'h000, 10'h000}, {10'h000, 10'h000}, {10'h200, 10'h200},
        {10'h040, 10'h200}, {10'h1A3, 10'h111}, {10'h3AC, 10'h2EE}, {10'h0F0, 10'h07F},
        {10'h2B7, 10'h380}, {10'h155, 10'h0AA}, {10'h3FE, 10'h001}, {10'h004, 10'h3FC},
        {10'h3FF, 10'h3FF}, {10'h000, 10'h000}, {10'h000, 10'h000}, {10'h274, 10'h274},
        {10'h155, 10'h2AA}, {10'h155, 10'h2AA}, {10'h155, 10'h2AA}, {10'h155, 10'h2AA},
        {10'h040, 10'h200}, {10'h040, 10'h200}, {10'h040, 10'h200}, {10'h040, 10'h200}
    };
    localparam logic [10:0] LINES [3] = '{11'h2A5, 11'h7FF, 11'h000};

    // reference model state, per stream
    logic [9:0]  m_h     [2][3];
    int          m_slot  [2];
    logic [17:0] m_crc   [2];
    bit          m_start [2];
    bit          m_en    [2];
    logic [10:0] m_ln    [2];

    function automatic logic [17:0] bench_crc(input logic [17:0] s, input logic [9:0] d);
        logic [17:0] r = s;
        for (int k = 0; k < 10; k++) begin
            logic f = r[0] ^ d[k];
            r = {1'b0, r[17:1]};
            if (f) r = r ^ 18'h23000;
        end
        return r;
    endfunction

    task automatic model_reset();
        for (int ch = 0; ch < 2; ch++) begin
            for (int k = 0; k < 3; k++) m_h[ch][k] = '0;
            m_slot[ch] = 0; m_crc[ch] = '0; m_start[ch] = 0; m_en[ch] = 0; m_ln[ch] = '0;
        end
    endtask

    task automatic model(input int ch, input logic [9:0] w, input logic [10:0] ln,
                         output logic [9:0] ex, output int kind);
        bit pre, eav, sav;
        pre = (m_h[ch][2] == 10'h3FF) && (m_h[ch][1] == 10'h000) && (m_h[ch][0] == 10'h000);
        eav = pre && w[6] && (m_slot[ch] == 0);
        sav = pre && !w[6];
        kind = m_slot[ch];
        case (m_slot[ch])
            1:       ex = {~m_ln[ch][6], m_ln[ch][6:0], 2'b00};
            2:       ex = {1'b1, 3'b000, m_ln[ch][10:7], 2'b00};
            3:       ex = {~m_crc[ch][8], m_crc[ch][8:0]};
            4:       ex = {~m_crc[ch][17], m_crc[ch][17:9]};
            default: ex = w;
        endcase
        if (m_start[ch] || m_en[ch]) m_crc[ch] = bench_crc(m_start[ch] ? 18'h0 : m_crc[ch], ex);
        if (m_slot[ch] == 2) m_en[ch] = 0;
        else if (m_start[ch]) m_en[ch] = 1;
        m_start[ch] = sav;
        if (eav) m_ln[ch] = ln;
        if (m_slot[ch] == 0) m_slot[ch] = eav ? 1 : 0;
        else m_slot[ch] = (m_slot[ch] == 4) ? 0 : m_slot[ch] + 1;
        m_h[ch][2] = m_h[ch][1]; m_h[ch][1] = m_h[ch][0]; m_h[ch][0] = w;
    endtask

    task automatic check(input string req, input string name, input logic [9:0] got,
                         input logic [9:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, name, got, exp);
        end
    endtask

    function automatic string tag_of(input int kind, input string pass_tag);
        if (kind == 0) return pass_tag;
        if (kind <= 2) return (pass_tag == "R4") ? "R4" : "R3";
        return "R5/R6";
    endfunction

    // drive one word pair at a negedge, check the outputs one clock later
    task automatic step(input logic [9:0] y, input logic [9:0] c, input logic [10:0] ln,
                        input string tag);
        logic [9:0] ey, ec;
        int ky, kc;
        y_in = y; c_in = c; line_num = ln;
        model(0, y, ln, ey, ky);
        model(1, c, ln, ec, kc);
        @(negedge clk);
        check(tag_of(ky, tag), $sformatf("Y slot%0d", ky), y_out, ey);
        check(tag_of(kc, tag), $sformatf("C slot%0d", kc), c_out, ec);
    endtask

    task automatic do_reset(input string tag);
        rst = 1'b1;
        y_in = 10'h3FF; c_in = 10'h3FF;
        @(negedge clk);
        check(tag, "Y reset", y_out, 10'h000);
        check(tag, "C reset", c_out, 10'h000);
        model_reset();
        rst = 1'b0;
    endtask

    initial begin
        #(200000 * 8);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        model_reset();
        repeat (2) @(negedge clk);
        // R8: reset state
        check("R8", "Y after reset", y_out, 10'h000);
        check("R8", "C after reset", c_out, 10'h000);
        rst = 1'b0;

        // R1 R3 R5 R6: whole lines with several line numbers
        for (int l = 0; l < 3; l++) begin
            for (int v = 0; v < NVEC; v++) begin
                step(VEC[v][19:10], VEC[v][9:0], LINES[l], "R1");
            end
        end

        // R2: broken prefix and opening reference do not insert
        step(10'h3FF, 10'h3FF, 11'h123, "R2");
        step(10'h000, 10'h000, 11'h123, "R2");
        step(10'h001, 10'h000, 11'h123, "R2");
        step(10'h274, 10'h000, 11'h123, "R2");
        for (int k = 0; k < 4; k++) step(10'h2D8, 10'h2D8, 11'h123, "R2");

        // R4: line number sampled with the status word only
        step(10'h3FF, 10'h3FF, 11'h6AB, "R4");
        step(10'h000, 10'h000, 11'h6AB, "R4");
        step(10'h000, 10'h000, 11'h6AB, "R4");
        step(10'h2D8, 10'h2D8, 11'h155, "R4");
        for (int k = 0; k < 6; k++) step(10'h040, 10'h200, 11'h6AB, "R4");

        // R7: closing reference on Y, opening reference on C
        step(10'h3FF, 10'h3FF, 11'h0F0, "R7");
        step(10'h000, 10'h000, 11'h0F0, "R7");
        step(10'h000, 10'h000, 11'h0F0, "R7");
        step(10'h274, 10'h200, 11'h0F0, "R7");
        for (int k = 0; k < 6; k++) step(10'h040, 10'h3C3, 11'h0F0, "R7");

        // R9: a closing reference landing inside the slots is ignored
        step(10'h3FF, 10'h3FF, 11'h301, "R9");
        step(10'h000, 10'h000, 11'h301, "R9");
        step(10'h000, 10'h000, 11'h301, "R9");
        step(10'h274, 10'h274, 11'h301, "R9");
        step(10'h3FF, 10'h3FF, 11'h301, "R9");
        step(10'h000, 10'h000, 11'h301, "R9");
        step(10'h000, 10'h000, 11'h301, "R9");
        step(10'h274, 10'h274, 11'h301, "R9");
        for (int k = 0; k < 4; k++) step(10'h0AB, 10'h1CD, 11'h301, "R9");

        // R8: reset in the middle of a slot sequence
        step(10'h3FF, 10'h3FF, 11'h444, "R8");
        step(10'h000, 10'h000, 11'h444, "R8");
        step(10'h000, 10'h000, 11'h444, "R8");
        step(10'h274, 10'h274, 11'h444, "R8");
        step(10'h111, 10'h222, 11'h444, "R8");
        do_reset("R8");
        for (int k = 0; k < 5; k++) step(10'h0C0 + 10'(k), 10'h300 + 10'(k), 11'h444, "R8");

        // R1: final full line after reset
        for (int v = 0; v < NVEC; v++) step(VEC[v][19:10], VEC[v][9:0], 11'h5A5, "R1");

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule